// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the raster timing for a display output: a horizontal and a vertical position counter, a data-enable window, horizontal sync, vertical sync, composite sync and a field flag. Both counters start at the top-left pixel of the active picture. Blanking and sync follow the active area within each line and within each field.

Progressive and interlaced scans are both supported. In interlaced mode, two sets of vertical geometry alternate field by field. Each set has its own line count, its own gap from the last active line to the start of vertical sync, and its own pixel position where vertical sync changes state. The odd field normally carries one line more than the even field and a larger gap. Its vertical-sync pixel position sits half a line earlier, so vertical sync lands half a line apart between the two fields. In progressive mode, the even set drives every frame.

All configuration is copied into a shadow set on the first cycle after reset and at each field boundary. The geometry therefore never changes inside a field. The surrounding logic drives the configuration inputs as static levels.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset is released, the first clock edge loads the shadow configuration and leaves both counters at 0. Each later edge advances `h_pos` by one. After `h_pos` = line total − 1, `h_pos` returns to 0 and `v_pos` advances. After the last line of the field, `v_pos` returns to 0. Position (0,0) is the top-left active pixel.
- R2: `de` is 1 exactly when `h_pos` < active width and `v_pos` < active height.
- R3: The non-inverted `hsync` is 1 when `hsync_start` ≤ `h_pos` < `hsync_end`.
- R4: Vertical sync starts at line `v_active` + gap and pixel `vs_hpos`. It ends at the same pixel `vs_lines` lines later. Gap and `vs_hpos` come from the parameter set of the current field.
- R5: `vsync_evt` is high for exactly one cycle, the cycle in which vertical sync starts, once per field or frame.
- R6: In interlaced mode, `field` alternates at every field boundary. `field` = 0 marks the odd field, which uses the odd line total, gap and sync position. `field` = 1 marks the even field. The first field after reset is even.
- R7: In progressive mode, `field` stays 1 and the even parameter set is used for every frame.
- R8: Each sync output is active high. Setting its invert input (`cfg_inv_hsync`, `cfg_inv_vsync`, `cfg_inv_csync`) makes that output active low.
- R9: The non-inverted `csync` is the OR of the non-inverted horizontal and vertical sync.
- R10: A configuration change made in the middle of a field has no effect until the next field boundary. This includes sync polarity and line length.
- R11: While reset is asserted, and up to the first edge after release, `h_pos` and `v_pos` are 0, `field` is 1, and `de`, `hsync`, `vsync`, `csync` and `vsync_evt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interlace | input | 1 | 1 selects interlaced scan |
| cfg_h_active | input | HW | Active pixels per line |
| cfg_h_total | input | HW | Pixel clocks per line |
| cfg_hs_start | input | HW | First pixel of horizontal sync |
| cfg_hs_end | input | HW | First pixel after horizontal sync |
| cfg_v_active | input | VW | Active lines per field or frame |
| cfg_even_lines | input | VW | Total lines, even field or progressive frame |
| cfg_even_gap | input | VW | Lines from end of active area to vertical sync, even field |
| cfg_even_vs_hpos | input | HW | Pixel where vertical sync toggles, even field |
| cfg_odd_lines | input | VW | Total lines, odd field |
| cfg_odd_gap | input | VW | Lines from end of active area to vertical sync, odd field |
| cfg_odd_vs_hpos | input | HW | Pixel where vertical sync toggles, odd field |
| cfg_vs_lines | input | VW | Vertical sync length in lines |
| cfg_inv_hsync | input | 1 | Make hsync active low |
| cfg_inv_vsync | input | 1 | Make vsync active low |
| cfg_inv_csync | input | 1 | Make csync active low |
| h_pos | output | HW | Horizontal position |
| v_pos | output | VW | Line within the current field |
| de | output | 1 | Data enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| csync | output | 1 | Composite sync |
| field | output | 1 | 0 = odd field, 1 = even field |
| vsync_evt | output | 1 | One-cycle pulse at the start of vertical sync |

## Verification
The assertions take a consistent geometry for granted:
- line total of at least two and larger than the active width;
- `hsync_start` < `hsync_end` ≤ line total;
- each `vs_hpos` below the line total;
- each field total larger than `v_active` + gap + `vs_lines`.

Every mode the stimulus programs meets these limits. The only mid-field change in the stimulus alters the line length or a polarity, and the new value stays consistent. Interlace is switched only between runs, each run beginning with a fresh reset, so the assertion that ties an odd field to interlaced mode sees a stable mode bit.

// File: rtl/rvt_pkg.sv
package rvt_pkg;
   typedef enum int unsigned {
      CSYNC_OR  = 0,
      CSYNC_XOR = 1
   } csync_kind_e;
endpackage

// File: rtl/rvt_shadow.sv
module rvt_shadow #(
   parameter int HW = 12,
   parameter int VW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          sel_odd,
   input  logic [HW-1:0] h_act_i,
   input  logic [HW-1:0] h_tot_i,
   input  logic [HW-1:0] hs_s_i,
   input  logic [HW-1:0] hs_e_i,
   input  logic [VW-1:0] v_act_i,
   input  logic [VW-1:0] ev_tot_i,
   input  logic [VW-1:0] ev_gap_i,
   input  logic [HW-1:0] ev_hp_i,
   input  logic [VW-1:0] od_tot_i,
   input  logic [VW-1:0] od_gap_i,
   input  logic [HW-1:0] od_hp_i,
   input  logic [VW-1:0] vs_len_i,
   input  logic          inv_hs_i,
   input  logic          inv_vs_i,
   input  logic          inv_cs_i,
   output logic [HW-1:0] h_act_q,
   output logic [HW-1:0] h_tot_q,
   output logic [HW-1:0] hs_s_q,
   output logic [HW-1:0] hs_e_q,
   output logic [VW-1:0] v_act_q,
   output logic [VW-1:0] v_tot_q,
   output logic [VW-1:0] vs_s_q,
   output logic [VW-1:0] vs_e_q,
   output logic [HW-1:0] vs_hp_q,
   output logic          inv_hs_q,
   output logic          inv_vs_q,
   output logic          inv_cs_q
);
   logic [VW-1:0] sel_tot, sel_gap, sel_vs_s;
   logic [HW-1:0] sel_hp;

   always_comb begin
      sel_tot  = sel_odd ? od_tot_i : ev_tot_i;
      sel_gap  = sel_odd ? od_gap_i : ev_gap_i;
      sel_hp   = sel_odd ? od_hp_i  : ev_hp_i;
      sel_vs_s = v_act_i + sel_gap;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_act_q  <= '0;
         h_tot_q  <= '0;
         hs_s_q   <= '0;
         hs_e_q   <= '0;
         v_act_q  <= '0;
         v_tot_q  <= '0;
         vs_s_q   <= '0;
         vs_e_q   <= '0;
         vs_hp_q  <= '0;
         inv_hs_q <= 1'b0;
         inv_vs_q <= 1'b0;
         inv_cs_q <= 1'b0;
      end else if (load) begin
         h_act_q  <= h_act_i;
         h_tot_q  <= h_tot_i;
         hs_s_q   <= hs_s_i;
         hs_e_q   <= hs_e_i;
         v_act_q  <= v_act_i;
         v_tot_q  <= sel_tot;
         vs_s_q   <= sel_vs_s;
         vs_e_q   <= sel_vs_s + vs_len_i;
         vs_hp_q  <= sel_hp;
         inv_hs_q <= inv_hs_i;
         inv_vs_q <= inv_vs_i;
         inv_cs_q <= inv_cs_i;
      end
   end
endmodule

// File: rtl/rvt_raster_cnt.sv
module rvt_raster_cnt #(
   parameter int HW = 12,
   parameter int VW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [HW-1:0] h_tot,
   input  logic [VW-1:0] v_tot,
   output logic [HW-1:0] h_q,
   output logic [VW-1:0] v_q,
   output logic          eof
);
   logic [HW-1:0] h_last;
   logic [VW-1:0] v_last;
   logic          eol;

   always_comb begin
      h_last = h_tot - 1'b1;
      v_last = v_tot - 1'b1;
      eol    = (h_q == h_last);
      eof    = run && eol && (v_q == v_last);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_q <= '0;
         v_q <= '0;
      end else if (run) begin
         if (eol) begin
            h_q <= '0;
            v_q <= (v_q == v_last) ? '0 : v_q + 1'b1;
         end else begin
            h_q <= h_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rvt_sync_decode.sv
module rvt_sync_decode
   import rvt_pkg::*;
#(
   parameter int          HW         = 12,
   parameter int          VW         = 11,
   parameter csync_kind_e CSYNC_KIND = CSYNC_OR
) (
   input  logic [HW-1:0] h,
   input  logic [VW-1:0] v,
   input  logic [HW-1:0] h_act,
   input  logic [HW-1:0] hs_s,
   input  logic [HW-1:0] hs_e,
   input  logic [VW-1:0] v_act,
   input  logic [VW-1:0] vs_s,
   input  logic [VW-1:0] vs_e,
   input  logic [HW-1:0] vs_hp,
   input  logic          inv_hs,
   input  logic          inv_vs,
   input  logic          inv_cs,
   output logic          de,
   output logic          hs,
   output logic          vs,
   output logic          cs,
   output logic          vs_start,
   output logic          vs_raw
);
   logic hs_raw, cs_raw, past_start, before_end;

   always_comb begin
      de         = (h < h_act) && (v < v_act);
      hs_raw     = (h >= hs_s) && (h < hs_e);
      past_start = (v > vs_s) || ((v == vs_s) && (h >= vs_hp));
      before_end = (v < vs_e) || ((v == vs_e) && (h < vs_hp));
      vs_raw     = past_start && before_end;
      vs_start   = (v == vs_s) && (h == vs_hp) && (vs_e != vs_s);
   end

   generate
      if (CSYNC_KIND == CSYNC_XOR) begin : g_cs_xor
         assign cs_raw = hs_raw ^ vs_raw;
      end else begin : g_cs_or
         assign cs_raw = hs_raw | vs_raw;
      end
   endgenerate

   assign hs = hs_raw ^ inv_hs;
   assign vs = vs_raw ^ inv_vs;
   assign cs = cs_raw ^ inv_cs;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rvt_pkg::*;
#(
   parameter int          HW         = 12,
   parameter int          VW         = 11,
   parameter csync_kind_e CSYNC_KIND = CSYNC_OR
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_interlace,
   input  logic [HW-1:0] cfg_h_active,
   input  logic [HW-1:0] cfg_h_total,
   input  logic [HW-1:0] cfg_hs_start,
   input  logic [HW-1:0] cfg_hs_end,
   input  logic [VW-1:0] cfg_v_active,
   input  logic [VW-1:0] cfg_even_lines,
   input  logic [VW-1:0] cfg_even_gap,
   input  logic [HW-1:0] cfg_even_vs_hpos,
   input  logic [VW-1:0] cfg_odd_lines,
   input  logic [VW-1:0] cfg_odd_gap,
   input  logic [HW-1:0] cfg_odd_vs_hpos,
   input  logic [VW-1:0] cfg_vs_lines,
   input  logic          cfg_inv_hsync,
   input  logic          cfg_inv_vsync,
   input  logic          cfg_inv_csync,
   output logic [HW-1:0] h_pos,
   output logic [VW-1:0] v_pos,
   output logic          de,
   output logic          hsync,
   output logic          vsync,
   output logic          csync,
   output logic          field,
   output logic          vsync_evt
);
   localparam int MIN_W = 4;

   generate
      if (HW < MIN_W) begin : g_bad_hw
         $error("raster_timing_gen: HW below minimum");
      end
      if (VW < MIN_W) begin : g_bad_vw
         $error("raster_timing_gen: VW below minimum");
      end
   endgenerate

   logic          primed, eof_w, load_w, field_next;
   logic [HW-1:0] h_act_q, h_tot_q, hs_s_q, hs_e_q, vs_hp_q;
   logic [VW-1:0] v_act_q, v_tot_q, vs_s_q, vs_e_q;
   logic          inv_hs_q, inv_vs_q, inv_cs_q, vs_raw_w;

   always_comb begin
      load_w     = !primed || eof_w;
      field_next = !primed ? 1'b1 : (cfg_interlace ? ~field : 1'b1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         primed <= 1'b0;
         field  <= 1'b1;
      end else begin
         primed <= 1'b1;
         if (load_w) field <= field_next;
      end
   end

   rvt_shadow #(.HW(HW), .VW(VW)) shadow_i (
      .clk(clk), .rst_n(rst_n), .load(load_w), .sel_odd(~field_next),
      .h_act_i(cfg_h_active), .h_tot_i(cfg_h_total),
      .hs_s_i(cfg_hs_start), .hs_e_i(cfg_hs_end), .v_act_i(cfg_v_active),
      .ev_tot_i(cfg_even_lines), .ev_gap_i(cfg_even_gap), .ev_hp_i(cfg_even_vs_hpos),
      .od_tot_i(cfg_odd_lines), .od_gap_i(cfg_odd_gap), .od_hp_i(cfg_odd_vs_hpos),
      .vs_len_i(cfg_vs_lines),
      .inv_hs_i(cfg_inv_hsync), .inv_vs_i(cfg_inv_vsync), .inv_cs_i(cfg_inv_csync),
      .h_act_q(h_act_q), .h_tot_q(h_tot_q), .hs_s_q(hs_s_q), .hs_e_q(hs_e_q),
      .v_act_q(v_act_q), .v_tot_q(v_tot_q), .vs_s_q(vs_s_q), .vs_e_q(vs_e_q),
      .vs_hp_q(vs_hp_q), .inv_hs_q(inv_hs_q), .inv_vs_q(inv_vs_q), .inv_cs_q(inv_cs_q)
   );

   rvt_raster_cnt #(.HW(HW), .VW(VW)) cnt_i (
      .clk(clk), .rst_n(rst_n), .run(primed),
      .h_tot(h_tot_q), .v_tot(v_tot_q),
      .h_q(h_pos), .v_q(v_pos), .eof(eof_w)
   );

   rvt_sync_decode #(.HW(HW), .VW(VW), .CSYNC_KIND(CSYNC_KIND)) dec_i (
      .h(h_pos), .v(v_pos), .h_act(h_act_q), .hs_s(hs_s_q), .hs_e(hs_e_q),
      .v_act(v_act_q), .vs_s(vs_s_q), .vs_e(vs_e_q), .vs_hp(vs_hp_q),
      .inv_hs(inv_hs_q), .inv_vs(inv_vs_q), .inv_cs(inv_cs_q),
      .de(de), .hs(hsync), .vs(vsync), .cs(csync),
      .vs_start(vsync_evt), .vs_raw(vs_raw_w)
   );
endmodule

// File: rtl/rvt_checker.sv
module rvt_checker #(
   parameter int HW = 12,
   parameter int VW = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic [HW-1:0] h_pos,
   input logic [VW-1:0] v_pos,
   input logic          de,
   input logic          field,
   input logic          vsync_evt,
   input logic          cfg_interlace,
   input logic          vs_raw
);
   // R1: a nonzero horizontal position is always one step past the previous one
   assert_hcount_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (h_pos != '0) |-> (h_pos == $past(h_pos) + 1'b1));

   // R2: the data window never overlaps vertical sync
   assert_de_not_in_vsync_R2: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> !vs_raw);

   // R5: the sync-start event lasts one cycle
   assert_vevt_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vsync_evt |=> !vsync_evt);

   // R6: the field flag moves only at the raster origin
   assert_field_at_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (field != $past(field)) |-> (h_pos == '0 && v_pos == '0));

   // R7: an odd field begins only when interlace was selected
   assert_odd_needs_interlace_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(field) |-> $past(cfg_interlace));
endmodule

bind raster_timing_gen rvt_checker #(.HW(HW), .VW(VW)) chk_i (
   .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .v_pos(v_pos), .de(de),
   .field(field), .vsync_evt(vsync_evt), .cfg_interlace(cfg_interlace),
   .vs_raw(vs_raw_w)
);

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;
   localparam int HW = 12;
   localparam int VW = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic          cfg_interlace, cfg_inv_hsync, cfg_inv_vsync, cfg_inv_csync;
   logic [HW-1:0] cfg_h_active, cfg_h_total, cfg_hs_start, cfg_hs_end;
   logic [HW-1:0] cfg_even_vs_hpos, cfg_odd_vs_hpos;
   logic [VW-1:0] cfg_v_active, cfg_even_lines, cfg_even_gap;
   logic [VW-1:0] cfg_odd_lines, cfg_odd_gap, cfg_vs_lines;
   logic [HW-1:0] h_pos;
   logic [VW-1:0] v_pos;
   logic de, hsync, vsync, csync, field, vsync_evt;

   always #2.5 clk = ~clk;

   raster_timing_gen #(.HW(HW), .VW(VW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_interlace(cfg_interlace),
      .cfg_h_active(cfg_h_active), .cfg_h_total(cfg_h_total),
      .cfg_hs_start(cfg_hs_start), .cfg_hs_end(cfg_hs_end),
      .cfg_v_active(cfg_v_active), .cfg_even_lines(cfg_even_lines),
      .cfg_even_gap(cfg_even_gap), .cfg_even_vs_hpos(cfg_even_vs_hpos),
      .cfg_odd_lines(cfg_odd_lines), .cfg_odd_gap(cfg_odd_gap),
      .cfg_odd_vs_hpos(cfg_odd_vs_hpos), .cfg_vs_lines(cfg_vs_lines),
      .cfg_inv_hsync(cfg_inv_hsync), .cfg_inv_vsync(cfg_inv_vsync),
      .cfg_inv_csync(cfg_inv_csync),
      .h_pos(h_pos), .v_pos(v_pos), .de(de), .hsync(hsync), .vsync(vsync),
      .csync(csync), .field(field), .vsync_evt(vsync_evt)
   );

   int n_run = 0;
   int n_fail = 0;
   int cur = 0;
   bit finished = 1'b0;

   // Mode: 16 clocks/line, 8 active pixels, hsync on pixels 10..11, 4 active lines.
   // Even: 8 lines, sync from (6,10) to (7,10). Odd: 9 lines, sync from (7,2) to (8,2).
   // Probe index = clock edges after the first post-reset edge.
   typedef struct packed {
      int   idx;
      int   h;
      int   v;
      logic f, de, hs, vs, cs, vp;
   } probe_t;

   localparam int NP = 24;
   localparam probe_t PROBES [NP] = '{
      '{0,   0,  0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{7,   7,  0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{8,   8,  0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{10,  10, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      '{11,  11, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      '{12,  12, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{55,  7,  3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{63,  15, 3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{64,  0,  4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{105, 9,  6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{106, 10, 6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
      '{107, 11, 6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
      '{121, 9,  7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      '{122, 10, 7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      '{127, 15, 7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{128, 0,  0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{234, 10, 6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      '{241, 1,  7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{242, 2,  7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
      '{257, 1,  8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      '{258, 2,  8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{271, 15, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{272, 0,  0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{378, 10, 6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}
   };

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s at index %0d: actual %0d expected %0d", tag, what, cur, act, exp);
      end
   endtask

   task automatic base_mode(input logic il);
      cfg_interlace    = il;
      cfg_h_active     = 12'd8;
      cfg_h_total      = 12'd16;
      cfg_hs_start     = 12'd10;
      cfg_hs_end       = 12'd12;
      cfg_v_active     = 11'd4;
      cfg_even_lines   = 11'd8;
      cfg_even_gap     = 11'd2;
      cfg_even_vs_hpos = 12'd10;
      cfg_odd_lines    = 11'd9;
      cfg_odd_gap      = 11'd3;
      cfg_odd_vs_hpos  = 12'd2;
      cfg_vs_lines     = 11'd1;
      cfg_inv_hsync    = 1'b0;
      cfg_inv_vsync    = 1'b0;
      cfg_inv_csync    = 1'b0;
   endtask

   // Assert reset, release it on a falling edge; returns just after the falling
   // edge that follows the first post-reset rising edge (index 0).
   task automatic prime();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur = 0;
   endtask

   task automatic goto(input int target);
      while (cur < target) begin
         @(negedge clk);
         cur++;
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      base_mode(1'b1);

      // R11: state while reset is held
      @(negedge clk);
      @(negedge clk);
      chk("R11", "h_pos", h_pos, 0);
      chk("R11", "v_pos", v_pos, 0);
      chk("R11", "field", field, 1);
      chk("R11", "de", de, 0);
      chk("R11", "hsync", hsync, 0);
      chk("R11", "vsync", vsync, 0);
      chk("R11", "csync", csync, 0);
      chk("R11", "vsync_evt", vsync_evt, 0);

      // Table walk: interlaced mode, two fields and into the third
      prime();
      for (int i = 0; i < NP; i++) begin
         goto(PROBES[i].idx);
         chk("R1", "h_pos", h_pos, PROBES[i].h);
         chk("R1", "v_pos", v_pos, PROBES[i].v);
         chk("R6", "field", field, PROBES[i].f);
         chk("R2", "de", de, PROBES[i].de);
         chk("R3", "hsync", hsync, PROBES[i].hs);
         chk("R4", "vsync", vsync, PROBES[i].vs);
         chk("R9", "csync", csync, PROBES[i].cs);
         chk("R5", "vsync_evt", vsync_evt, PROBES[i].vp);
      end

      // R7: progressive keeps the even set and field = 1
      base_mode(1'b0);
      prime();
      goto(128);
      chk("R7", "field", field, 1);
      chk("R7", "v_pos", v_pos, 0);
      goto(234);
      chk("R7", "vsync_evt", vsync_evt, 1);
      chk("R7", "vsync", vsync, 1);
      goto(242);
      chk("R7", "vsync", vsync, 1);
      goto(256);
      chk("R7", "field", field, 1);
      chk("R7", "h_pos", h_pos, 0);

      // R8: all sync outputs inverted
      base_mode(1'b1);
      cfg_inv_hsync = 1'b1;
      cfg_inv_vsync = 1'b1;
      cfg_inv_csync = 1'b1;
      prime();
      chk("R8", "hsync idle", hsync, 1);
      chk("R8", "vsync idle", vsync, 1);
      chk("R8", "csync idle", csync, 1);
      goto(10);
      chk("R8", "hsync active", hsync, 0);
      chk("R8", "csync active", csync, 0);
      goto(106);
      chk("R8", "vsync active", vsync, 0);

      // R10: mid-field changes wait for the field boundary
      base_mode(1'b0);
      prime();
      goto(5);
      cfg_inv_hsync = 1'b1;
      goto(10);
      chk("R10", "hsync polarity held", hsync, 1);
      goto(20);
      cfg_h_total = 12'd20;
      goto(127);
      chk("R10", "h_pos old length", h_pos, 15);
      chk("R10", "v_pos old length", v_pos, 7);
      goto(128);
      chk("R10", "h_pos at boundary", h_pos, 0);
      chk("R10", "v_pos at boundary", v_pos, 0);
      goto(138);
      chk("R10", "hsync new polarity", hsync, 0);
      goto(147);
      chk("R10", "h_pos new length", h_pos, 19);
      goto(148);
      chk("R10", "wrap new length h", h_pos, 0);
      chk("R10", "wrap new length v", v_pos, 1);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule